// File: doc/BRIEF.md
# HDLC Receive Queue with Frame Status Entries

This block sits between an HDLC receiver and the microcontroller that empties it. The receiver writes payload bytes one at a time. When a frame ends it raises a close event, and the queue stores a status entry carrying end-of-frame, abort and overrun bits. Data bytes and status entries share one storage array. A tag bit on each entry tells the reader which kind is at the head, so software can walk through a frame until it meets its status entry.

Fullness has two limits: byte space and the number of stored status entries. One storage slot and one status position are always held back. This guarantees that a frame cut short by lack of room can still be closed with an overrun status entry. After an overrun the queue refuses every write until the receiver is reinitialised. Five sticky interrupt flags report status-count exhaustion, end of frame, abort, fill threshold and overrun. They are cleared by a read strobe. The threshold flag re-arms only after the fill level has fallen far enough.

Top module: `rx_status_fifo`

## Requirements
- R1: Entries leave in the order they were written. `rdTag` is 0 for a data byte and 1 for a status entry. A status entry's byte has bit 0 = end of frame, bit 1 = abort, bit 2 = overrun, and all other bits 0.
- R2: After reset, and one cycle after `reinit`, the queue is empty (`rdValid` = 0). After reset, `irqStatus` = 0. `reinit` also lifts the overrun lock. It does not touch the flags.
- R3: A byte (`wrByte`) or a close (`wrClose`, which wins if both are high) is accepted only while at most DEPTH-2 entries are stored and at most STAT_MAX-2 of them are status entries. With the defaults, 63 bytes fit into an empty queue.
- R4: `irqStatus[0]` is set when a stored status entry brings the status count to STAT_MAX-1 or more (15 by default).
- R5: A write that finds no room stores the status entry 0x04 and sets `irqStatus[4]`. Every later byte and close is ignored, even after entries are popped, until `reinit`.
- R6: An accepted close with the end-of-frame bit set sets `irqStatus[1]`. An accepted close with the abort bit set sets `irqStatus[2]`.
- R7: While the threshold is armed, `irqStatus[3]` is set one cycle after the fill level becomes greater than or equal to `thresh`. Setting it disarms the threshold.
- R8: The threshold re-arms only when free space (DEPTH minus fill) exceeds `thresh`. Until then, reaching the threshold again sets no flag.
- R9: `irqStatus` shows the flags during the `irqRead` cycle. The next cycle they read 0, except flags whose set condition occurred in that same read cycle.
- R10: A push and a pop in the same cycle both take effect. The fill level stays consistent, so the queue drains to empty after exactly the entries written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reinit | input | 1 | Flush contents and lift the overrun lock |
| wrByte | input | 1 | Write a payload byte |
| wrData | input | 8 | Payload byte |
| wrClose | input | 1 | Close the current frame with a status entry |
| wrEof | input | 1 | End-of-frame bit for the close |
| wrAbrt | input | 1 | Abort bit for the close |
| rdPop | input | 1 | Remove the head entry |
| rdValid | output | 1 | Queue is not empty |
| rdTag | output | 1 | Head entry kind: 1 = status |
| rdData | output | 8 | Head entry byte |
| thresh | input | 7 | Fill-level threshold |
| irqRead | input | 1 | Read strobe for the interrupt flags (clear on read) |
| irqStatus | output | 5 | Flags: 0 status-full, 1 end of frame, 2 abort, 3 threshold, 4 overrun |

## Verification
Two events are made to fall in the same cycle. The first is a push and a pop together: bytes are written on every cycle while the draining monitor pops whenever the head is valid. The scoreboard judges that no entry is lost or repeated, and that the queue reads empty exactly when the expected list runs out. The second is a flag being set in the very cycle the flags are read: a close with the end-of-frame bit is driven together with the read strobe. The end-of-frame flag must still be set the cycle after, and a second read must then clear it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int BYTE_W = 8;
  localparam int IRQ_W  = 5;

  localparam int IRQ_STAT_FULL = 0;
  localparam int IRQ_EOF       = 1;
  localparam int IRQ_ABRT      = 2;
  localparam int IRQ_THR       = 3;
  localparam int IRQ_OVR       = 4;

  localparam int SW_EOF  = 0;
  localparam int SW_ABRT = 1;
  localparam int SW_OVR  = 2;

  typedef struct packed {
    logic              flush;
    logic              push;
    logic              pushTag;
    logic [BYTE_W-1:0] pushData;
    logic              pop;
  } fifoCmd_t;
endpackage

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  output logic              headTag,
  output logic [BYTE_W-1:0] headData
);
  logic [BYTE_W:0] mem [DEPTH];
  logic [AW-1:0]   wrPtr;
  logic [AW-1:0]   rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (cmd.push && !cmd.flush) begin
      mem[wrPtr] <= {cmd.pushTag, cmd.pushData};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (cmd.push) wrPtr <= nextPtr(wrPtr);
      if (cmd.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  assign {headTag, headData} = mem[rdPtr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int STAT_MAX = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(STAT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reinit,
  input  logic              wrByte,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrClose,
  input  logic              wrEof,
  input  logic              wrAbrt,
  input  logic              rdPop,
  input  logic [CW-1:0]     thresh,
  input  logic              irqRead,
  input  logic              headTag,
  output fifoCmd_t          cmd,
  output logic              rdValid,
  output logic [IRQ_W-1:0]  irqStatus
);
  logic [CW-1:0]    count, countNext, freeSpace;
  logic [SW-1:0]    statCount, statNext;
  logic             locked, armed;
  logic [IRQ_W-1:0] irqReg, irqSet;
  logic             hasRoom, wrAny, acceptByte, acceptClose, overrun, pushStat, thrHit;
  logic [BYTE_W-1:0] statusByte;

  always_comb begin
    hasRoom     = (count <= CW'(DEPTH - 2)) && (statCount <= SW'(STAT_MAX - 2));
    wrAny       = !locked && !reinit && (wrByte || wrClose);
    acceptClose = wrAny && wrClose && hasRoom;
    acceptByte  = wrAny && !wrClose && hasRoom;
    overrun     = wrAny && !hasRoom;
    pushStat    = acceptClose || overrun;

    statusByte = '0;
    if (overrun) begin
      statusByte[SW_OVR] = 1'b1;
    end else begin
      statusByte[SW_EOF]  = wrEof;
      statusByte[SW_ABRT] = wrAbrt;
    end

    cmd.flush    = reinit;
    cmd.push     = acceptByte || pushStat;
    cmd.pushTag  = pushStat;
    cmd.pushData = acceptByte ? wrData : statusByte;
    cmd.pop      = rdPop && (count != '0) && !reinit;

    countNext = count + CW'(cmd.push) - CW'(cmd.pop);
    statNext  = statCount + SW'(pushStat) - SW'(cmd.pop && headTag);
    freeSpace = CW'(DEPTH) - count;
    thrHit    = armed && (count >= thresh);

    irqSet                = '0;
    irqSet[IRQ_STAT_FULL] = pushStat && (statNext >= SW'(STAT_MAX - 1));
    irqSet[IRQ_EOF]       = acceptClose && wrEof;
    irqSet[IRQ_ABRT]      = acceptClose && wrAbrt;
    irqSet[IRQ_THR]       = thrHit && !reinit;
    irqSet[IRQ_OVR]       = overrun;
  end

  always_ff @(posedge clk) begin
    if (!rstN || reinit) begin
      count     <= '0;
      statCount <= '0;
      locked    <= 1'b0;
      armed     <= 1'b1;
    end else begin
      count     <= countNext;
      statCount <= statNext;
      locked    <= locked || overrun;
      if (thrHit)                 armed <= 1'b0;
      else if (freeSpace > thresh) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqReg <= '0;
    else       irqReg <= irqSet | (irqReg & ~{IRQ_W{irqRead}});
  end

  assign rdValid   = (count != '0);
  assign irqStatus = irqReg;
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int STAT_MAX = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reinit,
  input  logic              wrByte,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrClose,
  input  logic              wrEof,
  input  logic              wrAbrt,
  input  logic              rdPop,
  output logic              rdValid,
  output logic              rdTag,
  output logic [BYTE_W-1:0] rdData,
  input  logic [CW-1:0]     thresh,
  input  logic              irqRead,
  output logic [IRQ_W-1:0]  irqStatus
);
  fifoCmd_t cmd;
  logic     headTag;

  rxq_ctrl #(.DEPTH(DEPTH), .STAT_MAX(STAT_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .reinit(reinit),
    .wrByte(wrByte), .wrData(wrData), .wrClose(wrClose),
    .wrEof(wrEof), .wrAbrt(wrAbrt), .rdPop(rdPop),
    .thresh(thresh), .irqRead(irqRead), .headTag(headTag),
    .cmd(cmd), .rdValid(rdValid), .irqStatus(irqStatus)
  );

  rxq_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .headTag(headTag), .headData(rdData)
  );

  assign rdTag = headTag;
endmodule

// File: rtl/rx_status_fifo_chk.sv
module rx_status_fifo_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reinit,
  input logic       wrByte,
  input logic       wrClose,
  input logic       wrEof,
  input logic       wrAbrt,
  input logic       rdPop,
  input logic       rdValid,
  input logic       rdTag,
  input logic [7:0] rdData,
  input logic [4:0] irqStatus
);
  // R1
  head_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdPop && !reinit) |=> (rdValid && $stable(rdData) && $stable(rdTag)));

  // R2
  reinit_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    reinit |=> !rdValid);

  // R10
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdValid && !wrByte && !wrClose) |=> !rdValid);

  // R4
  stat_full_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[0]) |-> $past(wrByte || wrClose));

  // R5
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[4]) |-> $past(wrByte || wrClose));

  // R6
  eof_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[1]) |-> $past(wrClose && wrEof));

  // R6
  abrt_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[2]) |-> $past(wrClose && wrAbrt));
endmodule

bind rx_status_fifo rx_status_fifo_chk u_chk (
  .clk(clk), .rstN(rstN), .reinit(reinit), .wrByte(wrByte),
  .wrClose(wrClose), .wrEof(wrEof), .wrAbrt(wrAbrt), .rdPop(rdPop),
  .rdValid(rdValid), .rdTag(rdTag), .rdData(rdData), .irqStatus(irqStatus)
);

// File: tb/rx_status_fifo_tb.sv
module rx_status_fifo_tb;
  localparam int CLK_P    = 10;
  localparam int DEPTH    = 64;
  localparam int STAT_MAX = 16;

  logic       clk = 0, rstN = 0, reinit = 0;
  logic       wrByte = 0, wrClose = 0, wrEof = 0, wrAbrt = 0, rdPop = 0, irqRead = 0;
  logic [7:0] wrData = 0;
  logic [6:0] thresh = 7'd127;
  logic       rdValid, rdTag;
  logic [7:0] rdData;
  logic [4:0] irqStatus;

  int errors = 0, checks = 0, drainLeft = 0;
  bit mLocked = 0;
  logic [8:0] q[$];

  rx_status_fifo #(.DEPTH(DEPTH), .STAT_MAX(STAT_MAX)) u_dut (
    .clk(clk), .rstN(rstN), .reinit(reinit), .wrByte(wrByte), .wrData(wrData),
    .wrClose(wrClose), .wrEof(wrEof), .wrAbrt(wrAbrt), .rdPop(rdPop),
    .rdValid(rdValid), .rdTag(rdTag), .rdData(rdData), .thresh(thresh),
    .irqRead(irqRead), .irqStatus(irqStatus)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int statInQ();
    int n = 0;
    foreach (q[i]) if (q[i][8]) n++;
    return n;
  endfunction

  function automatic bit room();
    return (q.size() <= DEPTH - 2) && (statInQ() <= STAT_MAX - 2);
  endfunction

  // Monitor: compare head against expected queue, pop it on the next edge
  always @(negedge clk) begin
    rdPop = 0;
    if (rstN && drainLeft > 0 && rdValid) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1: actual=%0h expected=<none>", {rdTag, rdData});
      end else begin
        check("R1 order", {23'd0, rdTag, rdData}, {23'd0, q.pop_front()});
      end
      drainLeft--;
      rdPop = 1;
    end
  end

  task automatic putByte(input logic [7:0] b);
    wrByte = 1; wrData = b;
    if (!mLocked) begin
      if (room()) q.push_back({1'b0, b});
      else begin q.push_back(9'h104); mLocked = 1; end
    end
    @(negedge clk); wrByte = 0;
  endtask

  task automatic putClose(input logic e, input logic a);
    wrClose = 1; wrEof = e; wrAbrt = a;
    if (!mLocked) begin
      if (room()) q.push_back({1'b1, 5'd0, 1'b0, a, e});
      else begin q.push_back(9'h104); mLocked = 1; end
    end
    @(negedge clk); wrClose = 0; wrEof = 0; wrAbrt = 0;
  endtask

  task automatic doReinit();
    reinit = 1; q.delete(); mLocked = 0;
    @(negedge clk); reinit = 0;
  endtask

  task automatic clearIrq();
    irqRead = 1; @(negedge clk); irqRead = 0;
  endtask

  task automatic drain(input int n);
    drainLeft = n;
    wait (drainLeft == 0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset empty", rdValid, 0);
    check("R2 reset flags", irqStatus, 0);
    rstN = 1;
    @(negedge clk);

    // R1/R6: normal frame and abort frame
    putByte(8'h11); putByte(8'h22); putByte(8'h33); putClose(1, 0);
    check("R6 eof flag", irqStatus, 5'b00010);
    irqRead = 1;
    check("R9 visible on read", irqStatus, 5'b00010);
    @(negedge clk); irqRead = 0;
    check("R9 cleared after read", irqStatus, 0);
    drain(q.size());
    check("R1 drained", rdValid, 0);
    putByte(8'hA5); putClose(0, 1);
    check("R6 abort flag", irqStatus, 5'b00100);
    clearIrq();
    drain(q.size());

    // R10: push and pop in the same cycles
    drainLeft = 10;
    for (int i = 0; i < 10; i++) putByte(8'(8'h40 + i));
    wait (drainLeft == 0); @(negedge clk);
    check("R10 empty after overlap", rdValid, 0);
    check("R10 queue consumed", q.size(), 0);

    // R7/R8: threshold and hysteresis
    thresh = 7'd40;
    for (int i = 0; i < 40; i++) putByte(8'(i));
    @(negedge clk);
    check("R7 threshold set", irqStatus[3], 1);
    clearIrq();
    check("R9 threshold cleared", irqStatus[3], 0);
    drain(10);
    for (int i = 0; i < 10; i++) putByte(8'(8'h80 + i));
    repeat (2) @(negedge clk);
    check("R8 no rearm", irqStatus[3], 0);
    drain(17);
    for (int i = 0; i < 17; i++) putByte(8'(8'hC0 + i));
    repeat (2) @(negedge clk);
    check("R8 rearmed then set", irqStatus[3], 1);
    thresh = 7'd127;
    clearIrq();
    doReinit();
    check("R2 reinit empty", rdValid, 0);

    // R3/R5: byte space exhaustion
    for (int i = 0; i < 63; i++) putByte(8'(i + 1));
    check("R3 63 bytes no overrun", irqStatus[4], 0);
    putByte(8'hEE);
    check("R5 overrun flag", irqStatus[4], 1);
    putByte(8'h55); putClose(1, 0);
    drain(10);
    putByte(8'h66); putClose(1, 0);
    drain(q.size());
    check("R5 writes ignored while locked", rdValid, 0);
    check("R5 no eof while locked", irqStatus[1], 0);
    doReinit();
    clearIrq();
    putByte(8'h77); putClose(1, 0);
    check("R2 lock lifted", irqStatus[1], 1);
    drain(q.size());
    clearIrq();

    // R4/R3: status entry limit
    for (int i = 0; i < 14; i++) begin putByte(8'(i)); putClose(1, 0); end
    check("R4 not yet full", irqStatus[0], 0);
    putByte(8'h99); putClose(1, 0);
    check("R4 status full flag", irqStatus[0], 1);
    check("R3 no overrun at 15", irqStatus[4], 0);
    putByte(8'h98);
    check("R3 overrun by status count", irqStatus[4], 1);
    drain(q.size());
    check("R3 drained", rdValid, 0);
    doReinit();
    clearIrq();

    // R9: set and read in the same cycle
    irqRead = 1; wrClose = 1; wrEof = 1; q.push_back(9'h101);
    @(negedge clk);
    irqRead = 0; wrClose = 0; wrEof = 0;
    check("R9 set wins over read", irqStatus[1], 1);
    clearIrq();
    check("R9 second read clears", irqStatus[1], 0);
    drain(q.size());

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule